// File: doc/BRIEF.md
# Interrupt Controller Setup-Word Sequencer

This block sits behind the processor's register write port of an interrupt controller. It takes the byte stream software writes during start-up and walks through a sequence of up to four setup words. Each write carries an 8-bit data byte, a one-bit register select and a write strobe. A restart word begins the sequence. The second word always follows it. The third and fourth words are expected only when bits of the first word ask for them. The block keeps each word as it is accepted and raises a completion flag once the sequence has ended.

From the stored words and a 3-bit request level, the block forms the bytes the acknowledge logic later places on the data bus. There are two modes. In call-instruction mode the block forms a 16-bit call address, whose entries are spaced either 8 or 4 bytes apart. In vector-number mode it forms a single 8-bit vector number. Bit 0 of the fourth word selects the mode. These bytes are driven only while the completion flag is high.

Top module: `irq_init_seq`

## Requirements
- R1: While rst_n is low at a clock edge, init_done and every output byte go to zero after that edge, and the sequencer waits for a restart word.
- R2: A write with wr_sel=0 and wr_data bit 4 set is a restart word, in any state. It is stored as cfg_base, it clears cfg_high, cfg_link and cfg_opts, and init_done is low after that same edge.
- R3: The first wr_sel=1 write after a restart word is stored as cfg_high.
- R4: The next wr_sel=1 write is stored as cfg_link only when cfg_base bit 1 is 0. When that bit is 1, cfg_link stays zero and the word is not expected.
- R5: The next wr_sel=1 write is stored as cfg_opts only when cfg_base bit 0 is 1. Otherwise cfg_opts stays zero and the sequence ends without it.
- R6: A wr_sel=0 write with bit 4 clear is ignored at all times. A wr_sel=1 write is ignored once init_done is high. The stored words and init_done keep their values.
- R7: init_done goes high one clock after the edge that stores the last expected word. It is still low right after that edge.
- R8: In call-instruction mode (cfg_opts bit 0 = 0) with cfg_base bit 2 = 0, call_lo is {cfg_base[7:6], req_level, 3'b000}.
- R9: In call-instruction mode with cfg_base bit 2 = 1, call_lo is {cfg_base[7:5], req_level, 2'b00}.
- R10: In call-instruction mode, call_hi equals cfg_high and vec_num is zero.
- R11: In vector-number mode (cfg_opts bit 0 = 1), vec_num is {cfg_high[7:3], req_level}, and call_lo and call_hi are zero. mode_vec shows cfg_opts bit 0.
- R12: While init_done is low, call_lo, call_hi and vec_num are zero.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| wr_en | input | 1 | Write strobe, one write per cycle it is high |
| wr_sel | input | 1 | Register select of the write |
| wr_data | input | 8 | Write data byte |
| req_level | input | 3 | Request level used to form the output bytes |
| cfg_base | output | 8 | Stored first (restart) word |
| cfg_high | output | 8 | Stored second word |
| cfg_link | output | 8 | Stored third word, zero when skipped |
| cfg_opts | output | 8 | Stored fourth word, zero when skipped |
| init_done | output | 1 | Setup sequence complete |
| mode_vec | output | 1 | 1 = vector-number mode, 0 = call-instruction mode |
| call_lo | output | 8 | Low byte of the call address |
| call_hi | output | 8 | High byte of the call address |
| vec_num | output | 8 | Vector number |

## Verification
The hardest case to reach is a restart word that arrives partway through a sequence. Here cfg_high is already set but the sequence is not complete, and the stale second word must disappear. The bench stores a second word under a first word that still expects a third word. It then issues a fresh restart word and checks that cfg_high is zero. It also places an ignored select-0 write before the next second word, so that one short stretch covers R2, R6 and R7. The table-driven cases cover every combination of the skip bits, which leaves the sequence ending on the second, third or fourth word.

// File: rtl/irq_init_pkg.sv
// Shared types and field positions for the interrupt setup-word sequencer.
// Assumes 8-bit words and a 3-bit request level.
package irq_init_pkg;
    localparam int WORD_W = 8;
    localparam int LVL_W  = 3;

    // Field positions that the sequencer and the byte former both decode
    localparam int RESTART_BIT = 4;  // in a select-0 write: begins the sequence
    localparam int SINGLE_BIT  = 1;  // in the first word: 1 skips the third word
    localparam int NEED4_BIT   = 0;  // in the first word: 1 expects the fourth word
    localparam int STEP4_BIT   = 2;  // in the first word: 1 gives a 4-byte call spacing
    localparam int MODEV_BIT   = 0;  // in the fourth word: 1 selects vector-number mode

    typedef enum logic [2:0] {
        ST_IDLE,
        ST_W2,
        ST_W3,
        ST_W4,
        ST_LAST,
        ST_DONE
    } seq_state_t;

    function automatic logic is_restart(input logic sel, input logic [WORD_W-1:0] d);
        return (sel == 1'b0) && d[RESTART_BIT];
    endfunction
endpackage

// File: rtl/irq_init_fsm.sv
// Setup-word sequencer. It stores the restart word and the following words
// in order, and skips the third and fourth words as the first word requests.
// Assumes that at most one write arrives per cycle (wr_en) and a synchronous
// active-low reset.
module irq_init_fsm
    import irq_init_pkg::*;
#(
    parameter int DW = WORD_W
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          wr_en,
    input  logic          wr_sel,
    input  logic [DW-1:0] wr_data,
    output logic [DW-1:0] w1_q,
    output logic [DW-1:0] w2_q,
    output logic [DW-1:0] w3_q,
    output logic [DW-1:0] w4_q,
    output logic          done_q
);
    seq_state_t state_q;
    seq_state_t state_d;
    logic       restart;
    logic       data_wr;

    // Classify the current write
    always_comb begin
        restart = wr_en && is_restart(wr_sel, wr_data);
        data_wr = wr_en && wr_sel;
    end

    // Next-state decision, including the conditional skips
    always_comb begin
        state_d = state_q;
        if (restart) begin
            state_d = ST_W2;
        end else begin
            unique case (state_q)
                ST_W2: if (data_wr) begin
                    if (!w1_q[SINGLE_BIT])     state_d = ST_W3;
                    else if (w1_q[NEED4_BIT])  state_d = ST_W4;
                    else                       state_d = ST_LAST;
                end
                ST_W3: if (data_wr) begin
                    if (w1_q[NEED4_BIT])       state_d = ST_W4;
                    else                       state_d = ST_LAST;
                end
                ST_W4: if (data_wr)            state_d = ST_LAST;
                ST_LAST:                       state_d = ST_DONE;
                default:                       state_d = state_q;
            endcase
        end
    end

    // State register and completion flag
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q <= ST_IDLE;
            done_q  <= 1'b0;
        end else begin
            state_q <= state_d;
            done_q  <= (state_d == ST_DONE);
        end
    end

    // Store each accepted word; a restart clears the later words
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            w1_q <= '0;
            w2_q <= '0;
            w3_q <= '0;
            w4_q <= '0;
        end else if (restart) begin
            w1_q <= wr_data;
            w2_q <= '0;
            w3_q <= '0;
            w4_q <= '0;
        end else if (data_wr) begin
            unique case (state_q)
                ST_W2:   w2_q <= wr_data;
                ST_W3:   w3_q <= wr_data;
                ST_W4:   w4_q <= wr_data;
                default: ;
            endcase
        end
    end

    // R2
    restart_clears_chk: assert property (@(posedge clk) disable iff (!rst_n)
        restart |=> (!done_q && w2_q == '0 && w3_q == '0 && w4_q == '0));

    // R3
    second_word_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == ST_W2 && data_wr && !restart) |=> (w2_q == $past(wr_data)));

    // R6
    ignored_after_done_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (done_q && wr_en && !restart) |=>
            (done_q && $stable(w1_q) && $stable(w2_q) && $stable(w3_q) && $stable(w4_q)));

    // R7
    done_late_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!$past(done_q) && done_q) |-> !$past(data_wr));
endmodule

// File: rtl/irq_vec_form.sv
// Forms the call-address bytes and the vector number from the stored words
// and the request level. All outputs are held at zero until setup is complete.
// Assumes WORD_W is LVL_W plus at least 5 bits.
module irq_vec_form
    import irq_init_pkg::*;
#(
    parameter int DW = WORD_W,
    parameter int LW = LVL_W
) (
    input  logic [DW-1:0] w1,
    input  logic [DW-1:0] w2,
    input  logic [DW-1:0] w4,
    input  logic          done,
    input  logic [LW-1:0] level,
    output logic          mode_vec,
    output logic [DW-1:0] call_lo,
    output logic [DW-1:0] call_hi,
    output logic [DW-1:0] vec_num
);
    localparam int TOP8 = DW - LW - 3;  // base bits kept with 8-byte spacing
    localparam int TOP4 = DW - LW - 2;  // base bits kept with 4-byte spacing
    localparam int VTOP = DW - LW;      // high-word bits kept in the vector

    logic [DW-1:0] lo_step8;
    logic [DW-1:0] lo_step4;
    logic [DW-1:0] vec_raw;

    // Candidate bytes for both spacings and for the vector
    always_comb begin
        lo_step8 = {w1[DW-1 -: TOP8], level, 3'b000};
        lo_step4 = {w1[DW-1 -: TOP4], level, 2'b00};
        vec_raw  = {w2[DW-1 -: VTOP], level};
    end

    // Mode selection and gating by completion
    always_comb begin
        mode_vec = w4[MODEV_BIT];
        call_lo  = '0;
        call_hi  = '0;
        vec_num  = '0;
        if (done) begin
            if (mode_vec) begin
                vec_num = vec_raw;
            end else begin
                call_lo = w1[STEP4_BIT] ? lo_step4 : lo_step8;
                call_hi = w2;
            end
        end
    end

    // R8
    step8_low_zero_chk: assert final (!(done && !mode_vec && !w1[STEP4_BIT]) || call_lo[2:0] == 3'b000);
    // R9
    step4_low_zero_chk: assert final (!(done && !mode_vec && w1[STEP4_BIT]) || call_lo[1:0] == 2'b00);
endmodule

// File: rtl/irq_init_seq.sv
// Top of the interrupt setup-word sequencer. It joins the word sequencer and
// the output byte former. Writes are sampled on the rising clock edge; the
// reset is synchronous and active low.
module irq_init_seq
    import irq_init_pkg::*;
#(
    parameter int DW = WORD_W,
    parameter int LW = LVL_W
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          wr_en,
    input  logic          wr_sel,
    input  logic [DW-1:0] wr_data,
    input  logic [LW-1:0] req_level,
    output logic [DW-1:0] cfg_base,
    output logic [DW-1:0] cfg_high,
    output logic [DW-1:0] cfg_link,
    output logic [DW-1:0] cfg_opts,
    output logic          init_done,
    output logic          mode_vec,
    output logic [DW-1:0] call_lo,
    output logic [DW-1:0] call_hi,
    output logic [DW-1:0] vec_num
);
    irq_init_fsm #(.DW(DW)) i_fsm (
        .clk     (clk),
        .rst_n   (rst_n),
        .wr_en   (wr_en),
        .wr_sel  (wr_sel),
        .wr_data (wr_data),
        .w1_q    (cfg_base),
        .w2_q    (cfg_high),
        .w3_q    (cfg_link),
        .w4_q    (cfg_opts),
        .done_q  (init_done)
    );

    irq_vec_form #(.DW(DW), .LW(LW)) i_form (
        .w1       (cfg_base),
        .w2       (cfg_high),
        .w4       (cfg_opts),
        .done     (init_done),
        .level    (req_level),
        .mode_vec (mode_vec),
        .call_lo  (call_lo),
        .call_hi  (call_hi),
        .vec_num  (vec_num)
    );

    // R11
    vector_level_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (init_done && mode_vec) |-> (vec_num[LW-1:0] == req_level && call_hi == '0));

    // R12
    quiet_before_done_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !init_done |-> (call_lo == '0 && call_hi == '0 && vec_num == '0));

    // R4
    link_skipped_chk: assert property (@(posedge clk) disable iff (!rst_n)
        cfg_base[SINGLE_BIT] |-> (cfg_link == '0));
endmodule

// File: tb/test_irq_init_seq.sv
// Self-checking bench: a table of setup sequences, then directed tests.
module test_irq_init_seq;
    localparam int CLK_PERIOD = 10;

    logic       clk = 1'b0;
    logic       rst_n;
    logic       wr_en;
    logic       wr_sel;
    logic [7:0] wr_data;
    logic [2:0] req_level;
    logic [7:0] cfg_base, cfg_high, cfg_link, cfg_opts;
    logic       init_done, mode_vec;
    logic [7:0] call_lo, call_hi, vec_num;

    int checks = 0;
    int errors = 0;

    always #(CLK_PERIOD/2) clk = ~clk;

    irq_init_seq i_irq_init_seq (
        .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_sel(wr_sel),
        .wr_data(wr_data), .req_level(req_level),
        .cfg_base(cfg_base), .cfg_high(cfg_high), .cfg_link(cfg_link),
        .cfg_opts(cfg_opts), .init_done(init_done), .mode_vec(mode_vec),
        .call_lo(call_lo), .call_hi(call_hi), .vec_num(vec_num)
    );

    // Entries: {w1, w2, w3, w4, level, exp call_lo, exp call_hi, exp vec_num}
    localparam int NV = 6;
    localparam logic [63:0] TBL [NV] = '{
        64'h13_18_00_01_01_00_00_19,  // single, word4, vector mode
        64'hD6_3C_00_00_05_D4_3C_00,  // single, no word4, 4-byte spacing
        64'h50_A5_04_00_07_78_A5_00,  // word3, no word4, 8-byte spacing
        64'h91_47_02_01_06_00_00_46,  // word3 and word4, vector mode
        64'hF4_01_80_00_00_E0_01_00,  // word3, no word4, 4-byte spacing
        64'h17_FF_00_00_03_0C_FF_00   // single, word4 with call mode
    };

    task automatic chk(input string req, input logic [7:0] act, input logic [7:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s: actual=%h expected=%h", req, act, exp);
        end
    endtask

    // One write; returns at the falling edge after the capturing edge
    task automatic wr(input logic sel, input logic [7:0] d);
        wr_en = 1'b1; wr_sel = sel; wr_data = d;
        @(negedge clk);
        wr_en = 1'b0; wr_sel = 1'b0; wr_data = 8'h00;
    endtask

    initial begin
        repeat (20000) @(posedge clk);
        errors++;
        $display("FAIL watchdog: actual=hung expected=finished");
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

    initial begin
        rst_n = 1'b0; wr_en = 1'b0; wr_sel = 1'b0; wr_data = 8'h00; req_level = 3'd0;
        repeat (3) @(negedge clk);
        // R1: reset state
        chk("R1 done", {7'b0, init_done}, 8'h00);
        chk("R1 base", cfg_base, 8'h00);
        chk("R1 call_hi", call_hi, 8'h00);
        rst_n = 1'b1;
        @(negedge clk);

        for (int i = 0; i < NV; i++) begin
            logic [7:0] w1, w2, w3, w4, lvl, elo, ehi, evec;
            {w1, w2, w3, w4, lvl, elo, ehi, evec} = TBL[i];
            req_level = lvl[2:0];
            wr(1'b0, w1);
            wr(1'b1, w2);
            if (!w1[1]) wr(1'b1, w3);
            if (w1[0])  wr(1'b1, w4);
            chk("R7 done low after last word", {7'b0, init_done}, 8'h00);
            chk("R12 quiet before done", call_hi | vec_num | call_lo, 8'h00);
            @(negedge clk);
            chk("R7 done high", {7'b0, init_done}, 8'h01);
            chk("R3 second word", cfg_high, w2);
            chk("R4 third word", cfg_link, w3);
            chk("R5 fourth word", cfg_opts, w4);
            chk("R11 mode", {7'b0, mode_vec}, {7'b0, w4[0]});
            chk(w1[2] ? "R9 call_lo" : "R8 call_lo", call_lo, elo);
            chk("R10 call_hi", call_hi, ehi);
            chk("R11 vec_num", vec_num, evec);
        end

        // Restart partway through the sequence
        req_level = 3'd2;
        wr(1'b0, 8'h10);
        wr(1'b1, 8'h55);
        chk("R3 partial second word", cfg_high, 8'h55);
        chk("R12 partial quiet", call_hi, 8'h00);
        wr(1'b0, 8'h12);
        chk("R2 base restored", cfg_base, 8'h12);
        chk("R2 second cleared", cfg_high, 8'h00);
        wr(1'b0, 8'h08);
        chk("R6 select-0 ignored", cfg_base, 8'h12);
        chk("R6 second still empty", cfg_high, 8'h00);
        wr(1'b1, 8'h66);
        chk("R7 done low", {7'b0, init_done}, 8'h00);
        @(negedge clk);
        chk("R7 done high", {7'b0, init_done}, 8'h01);
        chk("R5 no fourth word", cfg_opts, 8'h00);
        wr(1'b1, 8'h77);
        chk("R6 late select-1 ignored", cfg_high, 8'h66);
        chk("R6 done kept", {7'b0, init_done}, 8'h01);
        wr(1'b0, 8'h0B);
        chk("R6 late select-0 ignored", cfg_base, 8'h12);
        chk("R8 call_lo", call_lo, 8'h10);
        chk("R10 call_hi", call_hi, 8'h66);

        // Restart after completion, then reset while done
        wr(1'b0, 8'h13);
        chk("R2 done dropped", {7'b0, init_done}, 8'h00);
        chk("R2 second cleared", cfg_high, 8'h00);
        req_level = 3'd4;
        wr(1'b1, 8'h20);
        wr(1'b1, 8'h01);
        @(negedge clk);
        chk("R11 vec_num", vec_num, 8'h24);
        chk("R11 call_lo zero", call_lo, 8'h00);
        rst_n = 1'b0;
        @(negedge clk);
        rst_n = 1'b1;
        chk("R1 done after reset", {7'b0, init_done}, 8'h00);
        chk("R1 base after reset", cfg_base, 8'h00);
        chk("R1 vec after reset", vec_num, 8'h00);

        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end
endmodule